// File: doc/BRIEF.md
# Upset-Masked Wired-OR Output Port Group

This block holds the output registers of a group of redundant processors whose corresponding output pins share one bus line each. Every pin of every processor has two latches: a data latch and a drive-enable latch. The pin drives a one onto the shared line only when both latches hold one. Every write loads the same value into both latches, so a zero command leaves both latches clear. A single upset in either latch therefore cannot put a one on the bus.

The shared line is modelled behaviourally as the OR of all processors' drives, and it falls to zero when no processor drives. Each processor has its own masked write port, a synchronous clear, and a readback of both latch banks so that software can scrub them. It also has an injection input that toggles any one chosen latch bit, so that the bench can model an upset.

Top module: `upm_port_group`

## Requirements
- R1: After the active-low asynchronous reset rst_ni, every data latch, every enable latch, every pin drive and every bus line reads zero.
- R2: A write on node n (wr_en_i[n]=1) sets both the data latch and the enable latch of every pin k whose mask bit is one to wr_data_i bit k, visible in the cycle after the clock edge.
- R3: Pins whose mask bit is zero, and all pins of a node that is not written, cleared or injected, keep both latch values.
- R4: pin_o bit k of node n is one exactly when that pin's data latch and enable latch are both one.
- R5: bus_o bit k is the OR of pin_o bit k over all nodes, and is zero when no node drives it.
- R6: Writing zero to a pin clears both its data latch and its enable latch.
- R7: With inj_en_i[n]=1, the selector value s toggles exactly one latch bit of node n: the data latch of pin s when s<W, the enable latch of pin s-W when W<=s<2W, and nothing when s>=2W. The toggle applies after the write or clear of the same cycle.
- R8: For any pin that is commanded to zero on every node, a single injected latch upset leaves that bus line at zero.
- R9: clr_i[n] clears both latch banks of node n on the next clock edge and takes priority over a write in the same cycle.
- R10: rd_data_o and rd_oe_o return the current data and enable latch values of each node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | N | Per-node synchronous clear |
| wr_en_i | input | N | Per-node write strobe |
| wr_mask_i | input | N*W | Per-node pin select for the write, node n in bits n*W+:W |
| wr_data_i | input | N*W | Per-node write value |
| inj_en_i | input | N | Per-node upset injection strobe |
| inj_sel_i | input | N*SELW | Per-node latch bit selector, node n in bits n*SELW+:SELW |
| rd_data_o | output | N*W | Data latch readback |
| rd_oe_o | output | N*W | Enable latch readback |
| pin_o | output | N*W | Per-node drive of each pin |
| bus_o | output | W | Resolved shared bus lines |

## Verification
The bench builds the block with its defaults: three nodes, eight pins and a five-bit selector. Three nodes give a genuine majority group, so OR resolution is exercised with one, two and three drivers. The five-bit selector reaches past 2W, so the out-of-range selector case of R7 can be tested alongside every data and enable latch position. With these values, an exhaustive sweep of all 48 single-latch upsets on a zero-commanded group is short enough to run in full, and pseudo-random traffic covers mixed writes, clears and injections.

// File: rtl/upm_pkg.sv
package upm_pkg;
  typedef enum logic [1:0] {
    LSEL_DATA = 2'd0,
    LSEL_OE   = 2'd1,
    LSEL_NONE = 2'd2
  } latch_kind_e;
endpackage

// File: rtl/upm_latch_bank.sv
module upm_latch_bank
  import upm_pkg::*;
#(
  parameter int W    = 8,
  parameter int SELW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            wr_en_i,
  input  logic [W-1:0]    wr_mask_i,
  input  logic [W-1:0]    wr_data_i,
  input  logic            inj_en_i,
  input  logic [SELW-1:0] inj_sel_i,
  output logic [W-1:0]    data_q_o,
  output logic [W-1:0]    oe_q_o
);
  localparam int NBITS = 2 * W;

  latch_kind_e kind;
  logic [W-1:0] flip_d, flip_oe;
  logic [W-1:0] load_d, load_oe;
  logic [W-1:0] data_q, oe_q;

  always_comb begin
    if (32'(inj_sel_i) < W)          kind = LSEL_DATA;
    else if (32'(inj_sel_i) < NBITS) kind = LSEL_OE;
    else                             kind = LSEL_NONE;
  end

  always_comb begin
    for (int k = 0; k < W; k++) begin
      flip_d[k]  = inj_en_i && (kind == LSEL_DATA) && (32'(inj_sel_i) == k);
      flip_oe[k] = inj_en_i && (kind == LSEL_OE)   && (32'(inj_sel_i) == k + W);
    end
  end

  // Both latches always load the same commanded value.
  always_comb begin
    if (clr_i) begin
      load_d  = '0;
      load_oe = '0;
    end else if (wr_en_i) begin
      load_d  = (data_q & ~wr_mask_i) | (wr_data_i & wr_mask_i);
      load_oe = (oe_q   & ~wr_mask_i) | (wr_data_i & wr_mask_i);
    end else begin
      load_d  = data_q;
      load_oe = oe_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      oe_q   <= '0;
    end else begin
      data_q <= load_d  ^ flip_d;
      oe_q   <= load_oe ^ flip_oe;
    end
  end

  assign data_q_o = data_q;
  assign oe_q_o   = oe_q;
endmodule

// File: rtl/upm_pin_drv.sv
module upm_pin_drv #(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] oe_i,
  output logic [W-1:0] drive_o
);
  for (genvar k = 0; k < W; k++) begin : g_pin
    // Released pin contributes nothing to the pulled-down line.
    assign drive_o[k] = oe_i[k] ? data_i[k] : 1'b0;
  end
endmodule

// File: rtl/upm_bus_or.sv
module upm_bus_or #(
  parameter int N = 3,
  parameter int W = 8
) (
  input  logic [N*W-1:0] drive_i,
  output logic [W-1:0]   bus_o
);
  for (genvar k = 0; k < W; k++) begin : g_line
    always_comb begin
      bus_o[k] = 1'b0;  // pull-down
      for (int n = 0; n < N; n++) bus_o[k] = bus_o[k] | drive_i[n*W+k];
    end
  end
endmodule

// File: rtl/upm_port_group.sv
module upm_port_group #(
  parameter int N    = 3,
  parameter int W    = 8,
  parameter int SELW = $clog2(2 * W) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    clr_i,
  input  logic [N-1:0]    wr_en_i,
  input  logic [N*W-1:0]  wr_mask_i,
  input  logic [N*W-1:0]  wr_data_i,
  input  logic [N-1:0]    inj_en_i,
  input  logic [N*SELW-1:0] inj_sel_i,
  output logic [N*W-1:0]  rd_data_o,
  output logic [N*W-1:0]  rd_oe_o,
  output logic [N*W-1:0]  pin_o,
  output logic [W-1:0]    bus_o
);
  for (genvar n = 0; n < N; n++) begin : g_node
    upm_latch_bank #(.W(W), .SELW(SELW)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr_i[n]),
      .wr_en_i  (wr_en_i[n]),
      .wr_mask_i(wr_mask_i[n*W +: W]),
      .wr_data_i(wr_data_i[n*W +: W]),
      .inj_en_i (inj_en_i[n]),
      .inj_sel_i(inj_sel_i[n*SELW +: SELW]),
      .data_q_o (rd_data_o[n*W +: W]),
      .oe_q_o   (rd_oe_o[n*W +: W])
    );

    upm_pin_drv #(.W(W)) u_drv (
      .data_i (rd_data_o[n*W +: W]),
      .oe_i   (rd_oe_o[n*W +: W]),
      .drive_o(pin_o[n*W +: W])
    );
  end

  upm_bus_or #(.N(N), .W(W)) u_bus (
    .drive_i(pin_o),
    .bus_o  (bus_o)
  );
endmodule

// File: rtl/upm_port_group_chk.sv
module upm_port_group_chk #(
  parameter int N    = 3,
  parameter int W    = 8,
  parameter int SELW = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N-1:0]    clr_i,
  input logic [N-1:0]    wr_en_i,
  input logic [N*W-1:0]  wr_mask_i,
  input logic [N*W-1:0]  wr_data_i,
  input logic [N-1:0]    inj_en_i,
  input logic [N*SELW-1:0] inj_sel_i,
  input logic [N*W-1:0]  rd_data_o,
  input logic [N*W-1:0]  rd_oe_o,
  input logic [N*W-1:0]  pin_o,
  input logic [W-1:0]    bus_o
);
  logic [W-1:0] col_or;
  always_comb begin
    col_or = '0;
    for (int n = 0; n < N; n++) col_or = col_or | pin_o[n*W +: W];
  end

  AST_BUS_RESOLVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_o == col_or) else $error("bus mismatch"); // R5

  for (genvar n = 0; n < N; n++) begin : g_chk
    AST_PIN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_o[n*W +: W] == (rd_data_o[n*W +: W] & rd_oe_o[n*W +: W])); // R4

    AST_WRITE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i[n] && !clr_i[n] && !inj_en_i[n]) |=>
        ((rd_data_o[n*W +: W] & $past(wr_mask_i[n*W +: W])) ==
         ($past(wr_data_i[n*W +: W]) & $past(wr_mask_i[n*W +: W]))) &&
        ((rd_oe_o[n*W +: W] & $past(wr_mask_i[n*W +: W])) ==
         ($past(wr_data_i[n*W +: W]) & $past(wr_mask_i[n*W +: W])))); // R2

    AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[n] && !inj_en_i[n]) |=>
        (rd_data_o[n*W +: W] == '0) && (rd_oe_o[n*W +: W] == '0)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i[n] && !clr_i[n] && !inj_en_i[n]) |=>
        $stable(rd_data_o[n*W +: W]) && $stable(rd_oe_o[n*W +: W])); // R3

    AST_ONE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i[n] && !clr_i[n] && inj_en_i[n]) |=>
        ($countones({rd_data_o[n*W +: W] ^ $past(rd_data_o[n*W +: W]),
                     rd_oe_o[n*W +: W]   ^ $past(rd_oe_o[n*W +: W])}) <= 1)); // R7
  end
endmodule

bind upm_port_group upm_port_group_chk #(.N(N), .W(W), .SELW(SELW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_i    (clr_i),
  .wr_en_i  (wr_en_i),
  .wr_mask_i(wr_mask_i),
  .wr_data_i(wr_data_i),
  .inj_en_i (inj_en_i),
  .inj_sel_i(inj_sel_i),
  .rd_data_o(rd_data_o),
  .rd_oe_o  (rd_oe_o),
  .pin_o    (pin_o),
  .bus_o    (bus_o)
);

// File: tb/upm_port_group_bench.sv
`timescale 1ns/1ps
module upm_port_group_bench;
  localparam int N    = 3;
  localparam int W    = 8;
  localparam int SELW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]      clr, wr_en, inj_en;
  logic [N*W-1:0]    wr_mask, wr_data;
  logic [N*SELW-1:0] inj_sel;
  logic [N*W-1:0]    rd_data, rd_oe, pin;
  logic [W-1:0]      bus;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  upm_port_group #(.N(N), .W(W), .SELW(SELW)) u_upm_port_group (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .wr_en_i(wr_en),
    .wr_mask_i(wr_mask), .wr_data_i(wr_data), .inj_en_i(inj_en),
    .inj_sel_i(inj_sel), .rd_data_o(rd_data), .rd_oe_o(rd_oe),
    .pin_o(pin), .bus_o(bus)
  );

  // Behavioural reference: per-node latch values.
  int m_d[N];
  int m_oe[N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_d[n]) begin m_d[n] = 0; m_oe[n] = 0; end
    end else begin
      for (int n = 0; n < N; n++) begin
        int msk, dat, s;
        msk = int'(wr_mask[n*W +: W]);
        dat = int'(wr_data[n*W +: W]);
        s   = int'(inj_sel[n*SELW +: SELW]);
        if (clr[n]) begin m_d[n] = 0; m_oe[n] = 0; end
        else if (wr_en[n]) begin
          m_d[n]  = (m_d[n]  & ~msk) | (dat & msk);
          m_oe[n] = (m_oe[n] & ~msk) | (dat & msk);
        end
        if (inj_en[n]) begin
          if (s < W) m_d[n] = m_d[n] ^ (1 << s);
          else if (s < 2*W) m_oe[n] = m_oe[n] ^ (1 << (s - W));
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int bus_exp;
      bus_exp = 0;
      for (int n = 0; n < N; n++) begin
        chk("R10 data readback", int'(rd_data[n*W +: W]), m_d[n]);
        chk("R10 enable readback", int'(rd_oe[n*W +: W]), m_oe[n]);
        chk("R4 pin drive", int'(pin[n*W +: W]), m_d[n] & m_oe[n]);
        bus_exp = bus_exp | (m_d[n] & m_oe[n]);
      end
      chk("R5 bus", int'(bus), bus_exp);
    end
  end

  task automatic idle_inputs();
    clr = '0; wr_en = '0; inj_en = '0;
    wr_mask = '0; wr_data = '0; inj_sel = '0;
  endtask

  task automatic cyc();
    @(posedge clk); #2;
    idle_inputs();
  endtask

  task automatic wr(int n, int msk, int dat);
    wr_en[n] = 1'b1;
    wr_mask[n*W +: W] = W'(msk);
    wr_data[n*W +: W] = W'(dat);
  endtask

  task automatic inj(int n, int s);
    inj_en[n] = 1'b1;
    inj_sel[n*SELW +: SELW] = SELW'(s);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 bus", int'(bus), 0);
    chk("R1 data", int'(rd_data), 0);
    chk("R1 enable", int'(rd_oe), 0);
    chk("R1 pins", int'(pin), 0);

    // R2 full write
    wr(0, 8'hFF, 8'hA5); cyc();
    chk("R2 data", int'(rd_data[0 +: W]), 8'hA5);
    chk("R2 enable", int'(rd_oe[0 +: W]), 8'hA5);
    chk("R2 bus", int'(bus), 8'hA5);

    // R3 / R6 masked write of zeros into low nibble
    wr(0, 8'h0F, 8'h00); cyc();
    chk("R3 upper pins held", int'(rd_data[0 +: W]) & 8'hF0, 8'hA0);
    chk("R6 data cleared", int'(rd_data[0 +: W]) & 8'h0F, 0);
    chk("R6 enable cleared", int'(rd_oe[0 +: W]) & 8'h0F, 0);
    chk("R3 other node held", int'(rd_data[W +: W]), 0);

    // R5 OR of two drivers
    wr(1, 8'hFF, 8'h0C); cyc();
    chk("R5 two drivers", int'(bus), 8'hAC);

    // R7 injection into node 2
    inj(2, 3); cyc();
    chk("R7 data bit 3", int'(rd_data[2*W +: W]), 8'h08);
    chk("R7 enable untouched", int'(rd_oe[2*W +: W]), 0);
    chk("R8 single upset bus", int'(bus), 8'hAC);
    inj(2, 4); cyc();
    inj(2, W + 4); cyc();
    chk("R7 enable bit 4", int'(rd_oe[2*W +: W]), 8'h10);
    chk("R7 double upset drives", int'(bus), 8'hBC);
    inj(2, 20); cyc();
    chk("R7 out of range data", int'(rd_data[2*W +: W]), 8'h18);
    chk("R7 out of range enable", int'(rd_oe[2*W +: W]), 8'h10);

    // R9 clear beats write
    clr[2] = 1'b1; wr(2, 8'hFF, 8'hFF); cyc();
    chk("R9 data", int'(rd_data[2*W +: W]), 0);
    chk("R9 enable", int'(rd_oe[2*W +: W]), 0);

    // R8 exhaustive single upsets on an all-zero group
    clr = '1; cyc();
    for (int n = 0; n < N; n++) begin
      for (int s = 0; s < 2*W; s++) begin
        inj(n, s); cyc();
        chk("R8 bus stays low", int'(bus), 0);
        inj(n, s); cyc();
        chk("R8 restored", int'(rd_data[n*W +: W]) | int'(rd_oe[n*W +: W]), 0);
      end
    end

    // R8 with other lines driven high by node 0
    wr(0, 8'hFF, 8'hF0); cyc();
    for (int s = 0; s < 2*W; s++) begin
      if ((s % W) < 4) begin
        inj(1, s); cyc();
        chk("R8 low nibble low", int'(bus) & 8'h0F, 0);
        inj(1, s); cyc();
      end
    end

    // Mixed pseudo-random traffic, checked by the per-cycle model compare
    for (int i = 0; i < 400; i++) begin
      for (int n = 0; n < N; n++) begin
        int r;
        r = int'($urandom % 16);
        if (r == 0) clr[n] = 1'b1;
        if (r < 6) wr(n, int'($urandom % 256), int'($urandom % 256));
        if (r > 12) inj(n, int'($urandom % 24));
      end
      cyc();
    end

    @(negedge clk); #1;
    finish_run();
  end
endmodule